// File: doc/BRIEF.md
# Recursive Polyphase Nth-Band Decimator

This block lowers the sample rate of a signed stream by a factor N (a power of two). Input samples are dealt out by a commutator to N parallel branches. Each branch is a chain of first-order allpass sections whose delays span N input samples. Every branch therefore works at the decimated rate and keeps one state word per section boundary. When a frame of N accepted samples is complete, all branches update together. Their outputs are summed, divided by N with rounding and saturated. The result appears with its own one-cycle strobe.

The input side is a sample plus a valid strobe, and samples may arrive with gaps of any length. The output side uses the same format. A larger total factor N1·N2·…·NK is built by chaining instances: each stage's output strobe and data feed the next stage's input. The filter coefficients are fixed parameters. With a passband edge near π/N, the structure cancels aliases that would fall into the passband. Aliases that land in the transition band are left in.

Top module: `nth_band_decim`

## Requirements
- R1: While rst_n is low (asynchronous), out_valid is 0 and out_data is 0. The frame position returns to the first slot, and every held sample and every section state is cleared to zero.
- R2: out_valid is high for exactly one cycle. It rises in the cycle after the clock edge that accepts the N-th sample of a frame (N = 2^LOG2N) and stays low in every other cycle.
- R3: A cycle with in_valid low accepts nothing. The frame position, all filter state and out_data are left unchanged.
- R4: The k-th accepted sample of a frame (k = 0 … N-1) feeds branch N-1-k, so branch n sees the input delayed by n samples relative to the frame's last sample. The coefficient of section s in branch n sits at COEFS[(n*SECTIONS+s)*CW +: CW], as a signed value with CW-1 fractional bits.
- R5: Each section computes y = rnd(γ·(x − y_old)) + x_old, where x_old and y_old are the section's own input and output from the previous frame. rnd adds 2^(CW-2) and then shifts arithmetically right by CW-1. Each section result wraps to W+GUARD bits in two's complement.
- R6: The output word is (Σ branch outputs + N/2) shifted arithmetically right by LOG2N, saturated to the signed W-bit range.
- R7: A constant input settles to an output equal to that constant within a few LSBs, because every allpass branch has unit gain at DC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe per decimated output |
| out_data | output | W | Signed decimated sample, held between strobes |

## Verification
The bench uses several stimulus patterns, each aimed at a different fault.
- A single impulse is placed at each of the N frame slots in turn. A wrong commutator order or a misplaced coefficient changes which impulse response appears.
- A long constant input shows whether the DC gain and the final divide by N are correct.
- Random samples with random gaps in in_valid show whether idle cycles disturb state or strobe timing.
- A run of full-scale random samples drives the sum into the saturation limits.
- A reset in the middle of a run shows that all held state is cleared.

// File: rtl/nth_band_decim.sv
module nth_band_decim #(
  parameter int W        = 16,
  parameter int LOG2N    = 2,
  parameter int SECTIONS = 2,
  parameter int CW       = 16,
  parameter int GUARD    = 3,
  parameter logic [(1<<LOG2N)*SECTIONS*CW-1:0] COEFS = {
    16'h6000, 16'h1000, 16'h4ccd, 16'he000,
    16'h5000, 16'h2000, 16'h3000, 16'h0ccd}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);
  localparam int N  = 1 << LOG2N;
  localparam int IW = W + GUARD;
  localparam int CF = CW - 1;
  localparam int PW = IW + CW + 1;
  localparam int SW = IW + LOG2N;
  localparam logic signed [PW-1:0] HALF  = PW'(1) <<< (CF - 1);
  localparam logic signed [SW-1:0] HALFN = SW'(1) <<< (LOG2N - 1);
  localparam logic signed [SW-1:0] MAXV  = SW'((1 << (W - 1)) - 1);
  localparam logic signed [SW-1:0] MINV  = -MAXV - SW'(1);
  localparam logic [LOG2N-1:0] LAST = LOG2N'(N - 1);

  logic [LOG2N-1:0]       slot;
  logic signed [W-1:0]    held [N-1];
  logic signed [IW-1:0]   st   [N][SECTIONS+1];
  logic signed [IW-1:0]   nxt  [N][SECTIONS+1];
  logic signed [SW-1:0]   sum, scaled, clipped;
  logic                   frame_done;

  assign frame_done = in_valid && (slot == LAST);

  for (genvar n = 0; n < N; n++) begin : g_br
    if (n == 0) begin : g_live
      assign nxt[n][0] = IW'(in_data);
    end else begin : g_held
      assign nxt[n][0] = IW'(held[N-1-n]);
    end
    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
      localparam logic signed [CW-1:0] G = COEFS[(n*SECTIONS+s)*CW +: CW];
      logic signed [IW:0]   diff;
      logic signed [PW-1:0] prod;
      assign diff = (IW+1)'(nxt[n][s]) - (IW+1)'(st[n][s+1]);
      assign prod = PW'(G) * PW'(diff);
      assign nxt[n][s+1] = IW'(((prod + HALF) >>> CF) + PW'(st[n][s]));
    end
  end

  always_comb begin
    sum = '0;
    for (int n = 0; n < N; n++) sum = sum + SW'(nxt[n][SECTIONS]);
  end

  assign scaled  = (sum + HALFN) >>> LOG2N;
  assign clipped = (scaled > MAXV) ? MAXV : ((scaled < MINV) ? MINV : scaled);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int k = 0; k < N-1; k++) held[k] <= '0;
      for (int n = 0; n < N; n++)
        for (int s = 0; s <= SECTIONS; s++) st[n][s] <= '0;
    end else begin
      out_valid <= frame_done;
      if (in_valid) begin
        slot <= slot + 1'b1;
        if (!frame_done) held[slot] <= in_data;
      end
      if (frame_done) begin
        out_data <= W'(clipped);
        for (int n = 0; n < N; n++)
          for (int s = 0; s <= SECTIONS; s++) st[n][s] <= nxt[n][s];
      end
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_frame_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && slot == LAST) |=> out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && slot == LAST) |=> !out_valid);
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(slot) && $stable(out_data) && $stable(st[0][SECTIONS])));
endmodule

// File: tb/nth_band_decim_tb.sv
`timescale 1ns/1ps
module nth_band_decim_tb_top;
  localparam int W = 16, LOG2N = 2, N = 4, S = 2, CW = 16, GUARD = 3;
  localparam int IW = W + GUARD, CF = CW - 1;
  localparam logic [N*S*CW-1:0] CO = {
    16'h6000, 16'h1000, 16'h4ccd, 16'he000,
    16'h5000, 16'h2000, 16'h3000, 16'h0ccd};

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic signed [W-1:0] in_data = '0;
  logic out_valid;
  logic signed [W-1:0] out_data;

  nth_band_decim #(.W(W), .LOG2N(LOG2N), .SECTIONS(S), .CW(CW), .GUARD(GUARD), .COEFS(CO))
    dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
           .out_valid(out_valid), .out_data(out_data));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  longint xd [N][S][N];
  longint yd [N][S][N];
  longint hist [N];
  longint m = 0, exp_d = 0;
  bit exp_v = 0;
  string tag = "R1";

  function automatic longint wrapb(longint v, int b);
    longint r = v & ((64'sd1 <<< b) - 1);
    if (r >= (64'sd1 <<< (b - 1))) r = r - (64'sd1 <<< b);
    return r;
  endfunction

  function automatic longint coef(int n, int s);
    logic signed [CW-1:0] c = CO[(n*S+s)*CW +: CW];
    return longint'(c);
  endfunction

  task automatic model_reset();
    for (int n = 0; n < N; n++) begin
      hist[n] = 0;
      for (int s = 0; s < S; s++)
        for (int p = 0; p < N; p++) begin xd[n][s][p] = 0; yd[n][s][p] = 0; end
    end
    m = 0; exp_v = 0; exp_d = 0;
  endtask

  // full-rate reference: every branch runs in z^N at each input index
  task automatic model_push(longint x);
    int ph = int'(m % N);
    longint acc = 0, o;
    for (int k = N-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    for (int n = 0; n < N; n++) begin
      longint v = hist[n];
      for (int s = 0; s < S; s++) begin
        longint p = coef(n, s) * (v - yd[n][s][ph]);
        longint y = wrapb(((p + (64'sd1 <<< (CF - 1))) >>> CF) + xd[n][s][ph], IW);
        xd[n][s][ph] = v;
        yd[n][s][ph] = y;
        v = y;
      end
      acc += v;
    end
    o = (acc + N/2) >>> LOG2N;
    if (o > 32767) o = 32767;
    if (o < -32768) o = -32768;
    if (ph == N-1) begin exp_v = 1; exp_d = o; end
    m++;
  endtask

  task automatic compare();
    checks++;
    if (out_valid !== exp_v) begin
      failures++;
      $display("FAIL %s/R2 out_valid=%0b expected=%0b", tag, out_valid, exp_v);
    end
    checks++;
    if (longint'(out_data) != exp_d) begin
      failures++;
      $display("FAIL %s/R5/R6 out_data=%0d expected=%0d", tag, out_data, exp_d);
    end
  endtask

  task automatic step(bit v, longint x, string t);
    @(negedge clk);
    compare();
    tag = t;
    in_valid = v;
    in_data = x[W-1:0];
    exp_v = 0;
    if (v) model_push(x);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    model_reset();
    tag = "R1";
    repeat (2) @(negedge clk);
    compare();
    rst_n = 1;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    // R4: impulse in each frame slot
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N*8; k++) step(1, (k == p) ? 8000 : 0, "R4");
      do_reset();
    end
    // R7: DC settling
    for (int k = 0; k < N*40; k++) step(1, 3000, "R7");
    step(0, 0, "R7");
    checks++;
    if (out_data > 3004 || out_data < 2996) begin
      failures++;
      $display("FAIL R7 out_data=%0d expected=3000+-4", out_data);
    end
    // R3: random data with random idle gaps
    for (int k = 0; k < 600; k++) begin
      int r = $urandom_range(0, 3);
      step(r != 0, longint'($urandom_range(0, 20000)) - 10000, "R3");
    end
    // R1: reset in mid-stream, then continue
    for (int k = 0; k < 3; k++) step(1, 1234, "R1");
    do_reset();
    for (int k = 0; k < N*6; k++) step(1, (k == 0) ? -5000 : 0, "R1");
    // R6: full-scale random drive towards saturation
    for (int k = 0; k < 800; k++)
      step(1, ($urandom_range(0, 1) == 1) ? 32767 : -32768, "R6");
    for (int k = 0; k < 4; k++) step(0, 0, "R6");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule